// File: doc/BRIEF.md
# Cipher Engine Register Controller

This block is the software-facing front end of a 128-bit block-cipher offload engine. It sits on a simple 32-bit register bus. It holds the job description: the mode bits, the source and destination addresses, the byte count, a 128-bit key and a 128-bit initialization vector. When software writes the control word with its start bit set, the block hands the job to a downstream cipher and transfer datapath through a one-cycle start pulse. It then waits for that datapath's done pulse.

When a job finishes, the block raises a pending flag on interrupt channel A. If the job ran in chained (CBC) mode, it also stores the returned chaining value in the IV words, so the next job can continue the chain. Software either polls the pending flag or enables it onto the interrupt line. It acknowledges by writing one to the pending bit, and the same write loads the mask bits.

Top module: `cipher_csr_seq`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq` and `dp_start` are low.
- R2: The byte offsets are 0x10 for the source address, 0x14 for the destination address and 0x18 for the length. Key word i is at 0x30+4i and IV word i is at 0x40+4i, and word i drives bits [32i+31:32i] of `dp_key` / `dp_iv`. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: The length register forces its four low bits to zero, so the count is always a whole number of 16-byte blocks.
- R4: The control word is at offset 0x00. Its bits are: 0 start, 1 encrypt (0 means decrypt), 2 load key, 3 destination coherent, 4 source coherent, 5 chained mode (0 means ECB). Bits 5:1 are stored and drive the matching `dp_*` outputs. A start with nonzero length gives a single-cycle `dp_start` in the cycle after the write. Bit 0 reads back as busy, which holds from the start write until done.
- R5: While busy, bus writes to the control, address, length, key and IV registers have no effect.
- R6: A `dp_done` while busy ends the job and sets channel A pending (interrupt register bit 16) in the next cycle. A `dp_done` while idle has no effect.
- R7: On done in chained mode, `dp_chain` is loaded into the IV words. In ECB mode the IV is unchanged.
- R8: A start with length zero issues no `dp_start`, does not become busy, and sets channel A pending in the next cycle.
- R9: The interrupt register is at offset 0x08. Writing one to bit 16 or bit 17 clears that pending bit, and the same write loads mask bits 2:0 from the write data. If completion and a clear fall in the same cycle, the completion wins.
- R10: `irq` is a registered copy of (channel A pending AND mask bit 0). It changes in the same cycle as the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| dp_start | output | 1 | One-cycle job launch |
| dp_src | output | 32 | Source address |
| dp_dst | output | 32 | Destination address |
| dp_len | output | 32 | Byte count |
| dp_encrypt | output | 1 | 1 encrypt, 0 decrypt |
| dp_key_load | output | 1 | Datapath should load `dp_key` |
| dp_dst_coh | output | 1 | Destination coherent transfer |
| dp_src_coh | output | 1 | Source coherent transfer |
| dp_cbc | output | 1 | Chained mode (0 means ECB) |
| dp_key | output | 128 | Key words |
| dp_iv | output | 128 | IV words |
| dp_done | input | 1 | Job finished pulse |
| dp_chain | input | 128 | Final chaining value, qualified by `dp_done` |
| irq | output | 1 | Interrupt line |

## Verification
The launch path is exercised with three control words. The first is an ECB encrypt with key load, and the IV must survive its completion. The second is a chained decrypt with both coherency flags, and the returned chain must land in the IV words. The third is a zero-length start, which must complete without a datapath pulse. Writes are also injected while a job is running, and each target is read back afterwards: this separates a correctly held register from one that silently takes the write. A stray done while idle, and a pending clear that collides with a completion in the same cycle, show whether the completion logic is qualified by busy and whether set outranks clear.

// File: rtl/cipher_csr_pkg.sv
package cipher_csr_pkg;
  localparam int unsigned OFF_CTRL = 32'h00;
  localparam int unsigned OFF_INTR = 32'h08;
  localparam int unsigned OFF_SRC  = 32'h10;
  localparam int unsigned OFF_DST  = 32'h14;
  localparam int unsigned OFF_LEN  = 32'h18;
  localparam int unsigned OFF_KEY  = 32'h30;
  localparam int unsigned OFF_IV   = 32'h40;

  localparam int CB_START = 0;
  localparam int CB_ENC   = 1;
  localparam int CB_KEYLD = 2;
  localparam int CB_DCOH  = 3;
  localparam int CB_SCOH  = 4;
  localparam int CB_CBC   = 5;

  localparam int PEND_LSB = 16;

  typedef struct packed {
    logic cbc;
    logic src_coh;
    logic dst_coh;
    logic key_ld;
    logic enc;
  } job_mode_t;
endpackage

// File: rtl/cipher_wordbank.sv
module cipher_wordbank #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int IDXW  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [DW-1:0]         wr_data,
  input  logic                  ld_en,
  input  logic [DW*WORDS-1:0]   ld_data,
  output logic [DW*WORDS-1:0]   q
);
  genvar g;
  generate
    for (g = 0; g < WORDS; g++) begin : gen_word
      always_ff @(posedge clk) begin
        if (rst) begin
          q[g*DW +: DW] <= '0;
        end else if (ld_en) begin
          q[g*DW +: DW] <= ld_data[g*DW +: DW];
        end else if (wr_en && (wr_idx == IDXW'(g))) begin
          q[g*DW +: DW] <= wr_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cipher_irq.sv
module cipher_irq #(
  parameter int NPEND = 2,
  parameter int NMASK = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NPEND-1:0] wr_clr,
  input  logic [NMASK-1:0] wr_mask,
  input  logic             set_a,
  output logic [NPEND-1:0] pend,
  output logic [NMASK-1:0] mask,
  output logic             irq
);
  logic [NPEND-1:0] pend_d;
  logic [NMASK-1:0] mask_d;

  always_comb begin
    pend_d = pend;
    mask_d = mask;
    if (wr_en) begin
      pend_d = pend & ~wr_clr;
      mask_d = wr_mask;
    end
    if (set_a) pend_d[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      mask <= mask_d;
      irq  <= pend_d[0] & mask_d[0];
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_a |=> pend[0]);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_clr[0] && !set_a) |=> !pend[0]);
  assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend[0] && mask[0]));
endmodule

// File: rtl/cipher_seq.sv
module cipher_seq (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic len_zero,
  input  logic dp_done,
  output logic busy,
  output logic dp_start,
  output logic job_end
);
  logic launch;

  assign launch  = start_req && !len_zero;
  assign job_end = (start_req && len_zero) || (busy && dp_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      dp_start <= 1'b0;
    end else begin
      dp_start <= launch;
      if (launch) busy <= 1'b1;
      else if (dp_done) busy <= 1'b0;
    end
  end

  assert_start_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    dp_start |-> busy);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (rst)
    dp_start |=> !dp_start);
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && dp_done) |=> !busy);
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (rst)
    (start_req && len_zero) |=> (!dp_start && !busy));
endmodule

// File: rtl/cipher_csr_seq.sv
module cipher_csr_seq
  import cipher_csr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int BLK_BITS  = 128,
  parameter int NPEND     = 2,
  parameter int NMASK     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                dp_start,
  output logic [DW-1:0]       dp_src,
  output logic [DW-1:0]       dp_dst,
  output logic [DW-1:0]       dp_len,
  output logic                dp_encrypt,
  output logic                dp_key_load,
  output logic                dp_dst_coh,
  output logic                dp_src_coh,
  output logic                dp_cbc,
  output logic [BLK_BITS-1:0] dp_key,
  output logic [BLK_BITS-1:0] dp_iv,
  input  logic                dp_done,
  input  logic [BLK_BITS-1:0] dp_chain,
  output logic                irq
);
  localparam int WORDS    = BLK_BITS / DW;
  localparam int IDXW     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BANK_LSB = IDXW + 2;
  localparam int BLK_LSB  = $clog2(BLK_BITS / 8);

  job_mode_t        mode_q;
  logic [DW-1:0]    src_q, dst_q, len_q;
  logic             busy, job_end, start_req;
  logic [NPEND-1:0] pend;
  logic [NMASK-1:0] mask;

  logic aligned, hit_ctrl, hit_intr, hit_src, hit_dst, hit_len, hit_key, hit_iv;
  logic wr_ok;
  logic [IDXW-1:0] word_idx;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign hit_ctrl = (bus_addr == AW'(OFF_CTRL));
  assign hit_intr = (bus_addr == AW'(OFF_INTR));
  assign hit_src  = (bus_addr == AW'(OFF_SRC));
  assign hit_dst  = (bus_addr == AW'(OFF_DST));
  assign hit_len  = (bus_addr == AW'(OFF_LEN));
  assign hit_key  = aligned &&
                    (bus_addr[AW-1:BANK_LSB] == (AW-BANK_LSB)'(OFF_KEY >> BANK_LSB));
  assign hit_iv   = aligned &&
                    (bus_addr[AW-1:BANK_LSB] == (AW-BANK_LSB)'(OFF_IV >> BANK_LSB));
  assign word_idx = bus_addr[BANK_LSB-1:2];

  assign wr_ok     = bus_wr && !busy;
  assign start_req = wr_ok && hit_ctrl && bus_wdata[CB_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
    end else if (wr_ok) begin
      if (hit_ctrl) begin
        mode_q.enc     <= bus_wdata[CB_ENC];
        mode_q.key_ld  <= bus_wdata[CB_KEYLD];
        mode_q.dst_coh <= bus_wdata[CB_DCOH];
        mode_q.src_coh <= bus_wdata[CB_SCOH];
        mode_q.cbc     <= bus_wdata[CB_CBC];
      end
      if (hit_src) src_q <= bus_wdata;
      if (hit_dst) dst_q <= bus_wdata;
      if (hit_len) len_q <= {bus_wdata[DW-1:BLK_LSB], {BLK_LSB{1'b0}}};
    end
  end

  cipher_wordbank #(.DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_key (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok && hit_key),
    .wr_idx  (word_idx),
    .wr_data (bus_wdata),
    .ld_en   (1'b0),
    .ld_data ({BLK_BITS{1'b0}}),
    .q       (dp_key)
  );

  cipher_wordbank #(.DW(DW), .WORDS(WORDS), .IDXW(IDXW)) u_iv (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_ok && hit_iv),
    .wr_idx  (word_idx),
    .wr_data (bus_wdata),
    .ld_en   (busy && dp_done && mode_q.cbc),
    .ld_data (dp_chain),
    .q       (dp_iv)
  );

  cipher_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .len_zero  (len_q == '0),
    .dp_done   (dp_done),
    .busy      (busy),
    .dp_start  (dp_start),
    .job_end   (job_end)
  );

  cipher_irq #(.NPEND(NPEND), .NMASK(NMASK)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_wr && hit_intr),
    .wr_clr  (bus_wdata[PEND_LSB +: NPEND]),
    .wr_mask (bus_wdata[NMASK-1:0]),
    .set_a   (job_end),
    .pend    (pend),
    .mask    (mask),
    .irq     (irq)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CB_START] = busy;
      rd_mux[CB_ENC]   = mode_q.enc;
      rd_mux[CB_KEYLD] = mode_q.key_ld;
      rd_mux[CB_DCOH]  = mode_q.dst_coh;
      rd_mux[CB_SCOH]  = mode_q.src_coh;
      rd_mux[CB_CBC]   = mode_q.cbc;
    end else if (hit_intr) begin
      rd_mux[PEND_LSB +: NPEND] = pend;
      rd_mux[NMASK-1:0]         = mask;
    end else if (hit_src) begin
      rd_mux = src_q;
    end else if (hit_dst) begin
      rd_mux = dst_q;
    end else if (hit_len) begin
      rd_mux = len_q;
    end else if (hit_key) begin
      rd_mux = dp_key[word_idx*DW +: DW];
    end else if (hit_iv) begin
      rd_mux = dp_iv[word_idx*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign dp_src      = src_q;
  assign dp_dst      = dst_q;
  assign dp_len      = len_q;
  assign dp_encrypt  = mode_q.enc;
  assign dp_key_load = mode_q.key_ld;
  assign dp_dst_coh  = mode_q.dst_coh;
  assign dp_src_coh  = mode_q.src_coh;
  assign dp_cbc      = mode_q.cbc;

  assert_len_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    dp_len[BLK_LSB-1:0] == '0);
  assert_src_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !dp_done) |=> ($stable(dp_src) && $stable(dp_key) && $stable(dp_cbc)));
  assert_iv_ecb_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && dp_done && !dp_cbc) |=> $stable(dp_iv));
  assert_iv_cbc_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && dp_done && dp_cbc) |=> (dp_iv == $past(dp_chain)));
endmodule

// File: tb/cipher_csr_seq_test.sv
`timescale 1ns/1ps
module cipher_csr_seq_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         dp_start, dp_encrypt, dp_key_load, dp_dst_coh, dp_src_coh, dp_cbc;
  logic [31:0]  dp_src, dp_dst, dp_len;
  logic [127:0] dp_key, dp_iv;
  logic         dp_done = 1'b0;
  logic [127:0] dp_chain = '0;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] rv;

  localparam logic [127:0] KEYV = {32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000};
  localparam logic [127:0] IVV  = {32'h5150_0003, 32'h5150_0002, 32'h5150_0001, 32'h5150_0000};
  localparam logic [127:0] CH1  = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
  localparam logic [127:0] CH2  = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;

  always #2.5 clk = ~clk;

  cipher_csr_seq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_start(dp_start),
    .dp_src(dp_src), .dp_dst(dp_dst), .dp_len(dp_len), .dp_encrypt(dp_encrypt),
    .dp_key_load(dp_key_load), .dp_dst_coh(dp_dst_coh), .dp_src_coh(dp_src_coh),
    .dp_cbc(dp_cbc), .dp_key(dp_key), .dp_iv(dp_iv), .dp_done(dp_done),
    .dp_chain(dp_chain), .irq(irq)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_job(input logic [127:0] ch);
    @(negedge clk);
    dp_done = 1'b1; dp_chain = ch;
    @(negedge clk);
    dp_done = 1'b0;
  endtask

  task automatic t_reset;
    rd(8'h00, rv); chk("R1 ctrl", rv, 0);
    rd(8'h08, rv); chk("R1 intr", rv, 0);
    rd(8'h18, rv); chk("R1 len", rv, 0);
    chk("R1 irq/start", {irq, dp_start}, 0);
    chk("R1 iv", dp_iv, 0);
  endtask

  task automatic t_map;
    wr(8'h10, 32'h1000_0000);
    wr(8'h14, 32'h2000_0000);
    wr(8'h18, 32'h0000_012B);
    rd(8'h10, rv); chk("R2 src", rv, 32'h1000_0000);
    rd(8'h14, rv); chk("R2 dst", rv, 32'h2000_0000);
    rd(8'h18, rv); chk("R3 len low bits cleared", rv, 32'h0000_0120);
    for (int i = 0; i < 4; i++) wr(8'h30 + 8'(4*i), 32'hA0A0_0000 + i);
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(4*i), 32'h5150_0000 + i);
    chk("R2 key words", dp_key, KEYV);
    chk("R2 iv words", dp_iv, IVV);
    rd(8'h38, rv); chk("R2 key word2 read", rv, 32'hA0A0_0002);
  endtask

  task automatic t_ecb_busy;
    wr(8'h00, 32'h07);
    chk("R4 start pulse", dp_start, 1);
    chk("R4 mode bits", {dp_cbc, dp_src_coh, dp_dst_coh, dp_key_load, dp_encrypt}, 5'b00011);
    @(negedge clk);
    chk("R4 start single", dp_start, 0);
    rd(8'h00, rv); chk("R4 ctrl busy read", rv, 32'h07);
    wr(8'h10, 32'hDEAD_0000);
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h30, 32'h0);
    wr(8'h00, 32'h21);
    rd(8'h10, rv); chk("R5 src held", rv, 32'h1000_0000);
    chk("R5 iv held", dp_iv, IVV);
    chk("R5 key held", dp_key, KEYV);
    chk("R5 mode held", {dp_cbc, dp_start}, 0);
    finish_job(CH1);
    chk("R7 ecb iv kept", dp_iv, IVV);
    chk("R10 masked irq", irq, 0);
    rd(8'h08, rv); chk("R6 pending set", rv, 32'h0001_0000);
    rd(8'h00, rv); chk("R6 busy cleared", rv, 32'h06);
  endtask

  task automatic t_clear_mask;
    wr(8'h08, 32'h0001_0001);
    rd(8'h08, rv); chk("R9 clear and mask", rv, 32'h0000_0001);
    chk("R10 irq low", irq, 0);
  endtask

  task automatic t_cbc;
    wr(8'h00, 32'h39);
    chk("R4 cbc decrypt bits", {dp_start, dp_cbc, dp_src_coh, dp_dst_coh, dp_key_load, dp_encrypt}, 6'b111100);
    @(negedge clk);
    dp_done = 1'b1; dp_chain = CH1;
    @(negedge clk);
    dp_done = 1'b0;
    chk("R7 chain latched", dp_iv, CH1);
    chk("R10 irq with pending", irq, 1);
    rd(8'h48, rv); chk("R7 iv word2", rv, CH1[95:64]);
  endtask

  task automatic t_idle_done;
    wr(8'h08, 32'h0001_0001);
    finish_job(CH2);
    chk("R6 idle done iv", dp_iv, CH1);
    rd(8'h08, rv); chk("R6 idle done pending", rv, 32'h0000_0001);
    chk("R6 idle done irq", irq, 0);
  endtask

  task automatic t_zero_len;
    wr(8'h18, 32'h0);
    wr(8'h00, 32'h03);
    chk("R8 no start", dp_start, 0);
    chk("R8 irq", irq, 1);
    rd(8'h00, rv); chk("R8 not busy", rv, 32'h02);
    rd(8'h08, rv); chk("R8 pending", rv, 32'h0001_0001);
  endtask

  task automatic t_collide;
    wr(8'h08, 32'h0001_0001);
    wr(8'h18, 32'h40);
    wr(8'h00, 32'h03);
    @(negedge clk);
    dp_done = 1'b1; dp_chain = CH2;
    bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h0001_0001;
    @(negedge clk);
    dp_done = 1'b0; bus_wr = 1'b0;
    rd(8'h08, rv); chk("R9 set beats clear", rv, 32'h0001_0001);
    wr(8'h08, 32'h0001_0000);
    rd(8'h08, rv); chk("R9 mask cleared", rv, 0);
    chk("R10 irq off", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_ecb_busy();
    t_clear_mask();
    t_cbc();
    t_idle_done();
    t_zero_len();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule